// File: doc/BRIEF.md
# Transmit DMA Request Controller

This block sits between a DMA engine and the transmit FIFO of a serial frame transmitter. It decides when to ask the DMA engine for more bytes. A request goes up only when a full block of 32 bytes fits into the FIFO. Each request is met by a burst of byte writes, and the request drops when the burst is complete.

There are two ways to run a frame. In counted mode a 12-bit byte count is loaded at start. The block asks for exactly that many bytes, cuts the last burst short to the remainder and marks the end of the frame with a one-cycle pulse. In continuous mode the count is ignored and full bursts keep coming for as long as space frees up. Clearing the continuous bit in mid-stream loads the count again, and exactly that many further bytes are then fetched. A stream that is still open ends on a FIFO underrun, which is a byte demand from the serializer while the FIFO is empty. The controller then raises an underrun flag, and the serializer answers it by sending idle ones without a CRC.

Top module: `txdma_req_ctrl`

## Requirements
- R1: A synchronous reset leaves `dma_req`, `frame_end` and `underrun` low.
- R2: While `dma_en` is low, `start` is ignored: no request is raised and no frame end is signalled.
- R3: `dma_req` rises only in an open stream, and only one cycle after `fifo_free` was at least 32 (the burst size).
- R4: In counted mode the number of accepted writes equals `byte_cnt` (1 to 4095). The bytes come in ceil(count/32) bursts. Every burst is 32 writes long except the last, which carries the remainder.
- R5: `frame_end` pulses high for one cycle right after the write that exhausts the count. A counted start with `byte_cnt` = 0 gives the pulse in the cycle after start and raises no request.
- R6: With `cont_mode` high, `byte_cnt` is ignored. Every burst is exactly 32 writes and no `frame_end` occurs.
- R7: Clearing `cont_mode` while a stream is open reloads `byte_cnt`. Exactly that many further writes are then accepted, followed by `frame_end`.
- R8: `ser_need` together with `fifo_empty` in an open stream sets `underrun` and drops `dma_req` on the next edge. The flag stays set until the next accepted start, which clears it.
- R9: `ser_need` with `fifo_empty` after a counted frame has completed does not set `underrun`.
- R10: A `dma_wr` strobe while `dma_req` is low is not counted against the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_en | input | 1 | DMA transfer mode enable |
| cont_mode | input | 1 | 1 = continuous, 0 = counted |
| byte_cnt | input | CNT_W (12) | Bytes per counted frame |
| start | input | 1 | Start command, one-cycle pulse |
| fifo_free | input | LVL_W (7) | Free bytes in transmit FIFO (0..64) |
| fifo_empty | input | 1 | Transmit FIFO holds no data |
| ser_need | input | 1 | Serializer wants a byte this cycle |
| dma_wr | input | 1 | DMA byte write strobe |
| dma_req | output | 1 | DMA request, registered |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| underrun | output | 1 | Sticky underrun flag: send idle ones, no CRC |

## Verification
The bench sweeps the counted frame lengths where the burst split is easy to get wrong: one byte, exactly one block, one byte over a block, exactly two blocks, and the 4095-byte maximum. A design that is off by one in its burst or remainder arithmetic would add or lose a byte, or would issue one burst too many. A continuous stream is run for many bursts and then switched back to counted mode between bursts. A design that kept its stale count, or never reloaded it, would fetch the wrong number of bytes or never end the frame. Further tests cover underrun stickiness, the zero-length frame, write strobes without a request, and demand on an empty FIFO after a frame has ended. A design that raised the flag after a clean end would make the serializer corrupt the next frame.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int unsigned TXD_CNT_W  = 12;
  localparam int unsigned TXD_DEPTH  = 64;
  localparam int unsigned TXD_BURST  = 32;

  typedef enum logic {
    MODE_COUNTED = 1'b0,
    MODE_CONT    = 1'b1
  } txd_mode_e;
endpackage

// File: rtl/txdma_remain_ctr.sv
module txdma_remain_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] rem,
  output logic             rem_one,
  output logic             rem_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (load) begin
      rem <= load_val;
    end else if (dec && rem != '0) begin
      rem <= rem - CNT_W'(1);
    end
  end

  assign rem_one  = (rem == CNT_W'(1));
  assign rem_zero = (rem == '0);
endmodule

// File: rtl/txdma_burst_ctr.sv
module txdma_burst_ctr #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned BURST = 32,
  parameter int unsigned BW    = $clog2(BURST + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop,
  input  logic             raise,
  input  logic             cont,
  input  logic [CNT_W-1:0] rem,
  input  logic             wr,
  input  logic             done,
  output logic             req
);
  logic [BW-1:0] left;
  logic [BW-1:0] len;

  // size of the burst about to be requested
  always_comb begin
    if (cont || rem >= CNT_W'(BURST)) len = BW'(BURST);
    else                              len = rem[BW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      req  <= 1'b0;
      left <= '0;
    end else if (raise) begin
      req  <= 1'b1;
      left <= len;
    end else if (wr) begin
      left <= left - BW'(1);
      if (left == BW'(1) || done) req <= 1'b0;
    end
  end
endmodule

// File: rtl/txdma_underrun_det.sv
module txdma_underrun_det (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic hit,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || clear) flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
  end
endmodule

// File: rtl/txdma_req_ctrl.sv
module txdma_req_ctrl import txdma_pkg::*; #(
  parameter int unsigned CNT_W      = TXD_CNT_W,
  parameter int unsigned FIFO_DEPTH = TXD_DEPTH,
  parameter int unsigned BURST      = TXD_BURST,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_en,
  input  logic             cont_mode,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             start,
  input  logic [LVL_W-1:0] fifo_free,
  input  logic             fifo_empty,
  input  logic             ser_need,
  input  logic             dma_wr,
  output logic             dma_req,
  output logic             frame_end,
  output logic             underrun
);
  txd_mode_e        mode, mode_q;
  logic             active;
  logic [CNT_W-1:0] rem;
  logic             rem_one, rem_zero;
  logic             start_acc, wr_acc, back_to_cnt, last_wr;
  logic             urun_hit, zero_cnt, stop, raise;

  assign mode        = cont_mode ? MODE_CONT : MODE_COUNTED;
  assign zero_cnt    = (byte_cnt == '0);
  assign start_acc   = start && dma_en;
  assign wr_acc      = dma_wr && dma_req;
  assign back_to_cnt = active && dma_en && mode_q == MODE_CONT && mode == MODE_COUNTED;
  assign last_wr     = wr_acc && mode == MODE_COUNTED && rem_one && !back_to_cnt;
  assign urun_hit    = active && ser_need && fifo_empty;
  assign stop        = !dma_en || urun_hit || start_acc || (back_to_cnt && zero_cnt);
  assign raise       = active && !dma_req && !back_to_cnt
                     && fifo_free >= LVL_W'(BURST)
                     && (mode == MODE_CONT || !rem_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      mode_q    <= MODE_COUNTED;
      frame_end <= 1'b0;
    end else begin
      mode_q    <= mode;
      frame_end <= last_wr
                || (start_acc && mode == MODE_COUNTED && zero_cnt)
                || (back_to_cnt && zero_cnt);
      if (start_acc)
        active <= (mode == MODE_CONT) || !zero_cnt;
      else if (!dma_en || urun_hit || last_wr || (back_to_cnt && zero_cnt))
        active <= 1'b0;
    end
  end

  txdma_remain_ctr #(.CNT_W(CNT_W)) u_remain (
    .clk      (clk),
    .rst      (rst),
    .load     (start_acc || back_to_cnt),
    .load_val (byte_cnt),
    .dec      (wr_acc && mode == MODE_COUNTED && !back_to_cnt),
    .rem      (rem),
    .rem_one  (rem_one),
    .rem_zero (rem_zero)
  );

  txdma_burst_ctr #(.CNT_W(CNT_W), .BURST(BURST)) u_burst (
    .clk   (clk),
    .rst   (rst),
    .stop  (stop),
    .raise (raise),
    .cont  (mode == MODE_CONT),
    .rem   (rem),
    .wr    (wr_acc),
    .done  (last_wr),
    .req   (dma_req)
  );

  txdma_underrun_det u_urun (
    .clk   (clk),
    .rst   (rst),
    .clear (start_acc),
    .hit   (urun_hit),
    .flag  (underrun)
  );
endmodule

// File: rtl/txdma_req_chk.sv
module txdma_req_chk #(
  parameter int unsigned LVL_W = 7,
  parameter int unsigned BURST = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             dma_en,
  input logic             cont_mode,
  input logic [LVL_W-1:0] fifo_free,
  input logic             dma_req,
  input logic             frame_end,
  input logic             underrun
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!dma_req && !frame_end && !underrun));

  // R2
  a_r2_off_no_req: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> !dma_req);

  // R3
  a_r3_req_needs_space: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> ($past(fifo_free) >= LVL_W'(BURST)));

  // R5
  a_r5_end_no_req: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !dma_req);

  // R6
  a_r6_no_end_in_cont: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !$past(cont_mode));

  // R8
  a_r8_underrun_blocks_req: assert property (@(posedge clk) disable iff (rst)
    underrun |-> !dma_req);
endmodule

bind txdma_req_ctrl txdma_req_chk #(.LVL_W(LVL_W), .BURST(BURST)) u_chk (.*);

// File: tb/tb_txdma_req_ctrl.sv
module tb_txdma_req_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dma_en = 1'b0, cont_mode = 1'b0, start = 1'b0;
  logic [11:0] byte_cnt = '0;
  logic [6:0]  fifo_free = 7'd64;
  logic        fifo_empty = 1'b0, ser_need = 1'b0, dma_wr = 1'b0;
  logic        dma_req, frame_end, underrun;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int writes, ends, bursts, cur, last_len, max_len, min_len;
  bit wr_drv = 1'b0, resp_on = 1'b1;

  // {count, expected bursts, expected last burst length}
  localparam int VEC [6][3] = '{
    '{1, 1, 1}, '{32, 1, 32}, '{33, 2, 1},
    '{64, 2, 32}, '{100, 4, 4}, '{4095, 128, 31}};

  always #10 clk = ~clk;

  txdma_req_ctrl dut (
    .clk(clk), .rst(rst), .dma_en(dma_en), .cont_mode(cont_mode),
    .byte_cnt(byte_cnt), .start(start), .fifo_free(fifo_free),
    .fifo_empty(fifo_empty), .ser_need(ser_need), .dma_wr(dma_wr),
    .dma_req(dma_req), .frame_end(frame_end), .underrun(underrun));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_stats();
    writes = 0; ends = 0; bursts = 0; cur = 0;
    last_len = 0; max_len = 0; min_len = 1000;
  endtask

  // DMA responder: writes one byte per cycle while the request is up
  task automatic pump(input int ncyc, input bit until_end);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (wr_drv) begin writes++; cur++; end
      if (frame_end) ends++;
      if (!dma_req && cur > 0) begin
        bursts++; last_len = cur;
        if (cur > max_len) max_len = cur;
        if (cur < min_len) min_len = cur;
        cur = 0;
      end
      wr_drv = dma_req && resp_on;
      dma_wr = wr_drv;
      if (until_end && ends > 0) break;
    end
    @(negedge clk);
    if (wr_drv) begin writes++; cur++; end
    if (frame_end) ends++;
    wr_drv = 1'b0; dma_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req after reset", dma_req, 0);
    check("R1 frame_end after reset", frame_end, 0);
    check("R1 underrun after reset", underrun, 0);

    // R2: DMA mode off
    cont_mode = 1'b1; byte_cnt = 12'd20;
    pulse_start();
    clr_stats(); pump(30, 1'b0);
    check("R2 writes with dma off", writes, 0);
    check("R2 frame_end with dma off", ends, 0);

    // R4/R5: table of counted frames
    dma_en = 1'b1; cont_mode = 1'b0;
    foreach (VEC[k]) begin
      byte_cnt = 12'(VEC[k][0]);
      pulse_start();
      clr_stats(); pump(6000, 1'b1);
      check("R4 bytes accepted", writes, VEC[k][0]);
      check("R4 burst count", bursts, VEC[k][1]);
      check("R4 last burst length", last_len, VEC[k][2]);
      check("R4 max burst", (max_len <= 32) ? 1 : 0, 1);
      check("R5 one frame_end", ends, 1);
    end

    // R5: zero-length counted frame
    byte_cnt = 12'd0;
    pulse_start();
    check("R5 zero count frame_end", frame_end, 1);
    check("R5 zero count no req", dma_req, 0);
    clr_stats(); pump(20, 1'b0);
    check("R5 zero count writes", writes, 0);

    // R3 and R10: too little space, stray strobes
    fifo_free = 7'd31; byte_cnt = 12'd10;
    pulse_start();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); dma_wr = 1'b1;
    end
    @(negedge clk); dma_wr = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 no req below 32 free", dma_req, 0);
    fifo_free = 7'd32;
    @(negedge clk);
    check("R3 req once 32 free", dma_req, 1);
    fifo_free = 7'd64;
    clr_stats(); pump(200, 1'b1);
    check("R10 stray strobes not counted", writes, 10);

    // R6: continuous stream ignores the count
    cont_mode = 1'b1; byte_cnt = 12'd5;
    pulse_start();
    clr_stats(); pump(300, 1'b0);
    check("R6 count ignored", (writes > 200) ? 1 : 0, 1);
    check("R6 bursts full size", min_len, 32);
    check("R6 no frame_end", ends, 0);

    // R7: back to counted mode between bursts
    fifo_free = 7'd0;
    pump(40, 1'b0);
    check("R7 idle before switch", dma_req, 0);
    @(negedge clk); cont_mode = 1'b0; byte_cnt = 12'd40;
    @(negedge clk); fifo_free = 7'd64;
    clr_stats(); pump(300, 1'b1);
    check("R7 further bytes", writes, 40);
    check("R7 frame_end after reload", ends, 1);

    // R8: underrun in an open continuous stream
    cont_mode = 1'b1; resp_on = 1'b0;
    pulse_start();
    clr_stats(); pump(4, 1'b0);
    check("R8 req up before underrun", dma_req, 1);
    @(negedge clk); ser_need = 1'b1; fifo_empty = 1'b1;
    @(negedge clk); ser_need = 1'b0; fifo_empty = 1'b0;
    check("R8 underrun set", underrun, 1);
    check("R8 req dropped", dma_req, 0);
    repeat (6) @(negedge clk);
    check("R8 underrun sticky", underrun, 1);
    check("R8 req stays low", dma_req, 0);
    resp_on = 1'b1; cont_mode = 1'b0; byte_cnt = 12'd3;
    pulse_start();
    check("R8 start clears underrun", underrun, 0);
    clr_stats(); pump(100, 1'b1);
    check("R8 next frame bytes", writes, 3);

    // R9: empty-FIFO demand after a finished frame
    @(negedge clk); ser_need = 1'b1; fifo_empty = 1'b1;
    @(negedge clk); ser_need = 1'b0; fifo_empty = 1'b0;
    @(negedge clk);
    check("R9 no underrun after frame end", underrun, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule